// File: doc/BRIEF.md
# Bus-Takeover Debug Sequencer

This block is a small programmable engine that can seize the external bus of a host CPU so that the CPU can be halted, examined and guided from outside. A supervisor loads a short routine into a shared memory. The sequencer then runs that routine. Its instructions sample the live bus pins into registers, drive words onto the data lines, pulse the CPU control lines, and block until a given bus event happens.

The sequencer has one memory port with a registered read. Through it, the sequencer fetches 16-bit instructions from a 256-word program area. The same port gives access to sixteen 16-bit working registers placed directly above that area. Because one port serves both instruction fetch and register access, each instruction takes at least five cycles. The same constraint is why comparisons go through a single compare register. When the sequencer owns the bus, an enable output tells the normal bus controller to stand aside.

Top module: `dbg_seq`

## Requirements
- R1: Every instruction passes through the states LATCH, FETCH, LOAD, EXEC and STORE in that order. Memory reads return data one cycle after the address. memAddr 0x000-0x0FF selects a program word and 0x100+n selects register n. memWrEn is raised only in STORE and only with memAddr in the register region. After reset, memAddr reads 0x000, 0x001, 0x10d, 0x10d, then 0x10d with the write.
- R2: Word encoding: opcode in bits [15:8], destination/source register in [3:0], MOV source in [7:4], branch target in [7:0]. Opcodes (hex): NOP 00, ATTACH 01, DETACH 02, LDD 03, LDAL 04, LDAH 05, LDWR 06, LDDC 07, LDMIO 08, STD 09, START 0A, RESET 0B, READY 0C, LDI 0D, MOV 0E, CLR 0F, LDCMP 10, CMP 11, BA 12, BEQ 13, BNE 14, HOLD 15, INT 16, WAITADS 17, WAITIO 18, WAITLOCK 19, EXIT 1A, NMI 1B. LDI takes its immediate from the next word and advances the program counter by two. Other instructions advance it by one.
- R3: LDCMP copies a register into the compare register. CMP replaces the compare register with 1 if it equals the register, and 0 otherwise. BEQ jumps when the compare register is nonzero, BNE jumps when it is zero, and BA always jumps.
- R4: LDI writes the immediate, MOV writes the source register's value, and CLR writes zero to the destination register.
- R5: LDD stores busData. LDAL stores busAddr[15:0]. LDAH stores busAddr[23:16] zero-extended. LDWR, LDDC and LDMIO store busWr, busDc and busMio in bit 0.
- R6: ATTACH raises busEn. DETACH lowers busEn and also releases dataOe and cpuHold.
- R7: STD places a register on dataOut and raises dataOe. READY drives readyN low.
- R8: RESET raises cpuReset and START lowers it.
- R9: HOLD raises cpuHold and does not continue until holdAck is high.
- R10: INT raises cpuIntr, waits for intAck, then lowers cpuIntr and continues.
- R11: WAITADS waits for busAdsN low. WAITIO also needs busMio low, so memory cycles are ignored. WAITLOCK also needs busLockN low. On a match, readyN goes high and busEn goes high.
- R12: NMI raises cpuNmi. A WAITLOCK match lowers it.
- R13: EXIT stalls for good with stopFlag high and makes no further writes. A synchronous rst restarts execution at address 0 with stopFlag low, busEn low, readyN high, and cpuReset, cpuHold, cpuIntr, cpuNmi and dataOe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, restart at program word 0 |
| memAddr | output | 9 | Shared memory word address |
| memRdData | input | 16 | Registered read data, valid one cycle after address |
| memWrEn | output | 1 | Register write strobe |
| memWrData | output | 16 | Register write data |
| busAdsN | input | 1 | CPU address strobe, active low |
| busAddr | input | 24 | CPU address bus |
| busData | input | 16 | CPU data bus as seen on the pins |
| busWr | input | 1 | Write/read cycle indicator |
| busDc | input | 1 | Data/control cycle indicator |
| busMio | input | 1 | Memory/IO cycle indicator (low = IO) |
| busLockN | input | 1 | Bus lock, active low |
| holdAck | input | 1 | Hold acknowledge |
| intAck | input | 1 | Interrupt acknowledge |
| busEn | output | 1 | Sequencer owns the CPU bus |
| readyN | output | 1 | CPU ready, active low |
| dataOut | output | 16 | Value to drive on the data bus |
| dataOe | output | 1 | Data bus drive enable |
| cpuReset | output | 1 | CPU reset line |
| cpuHold | output | 1 | CPU bus hold request |
| cpuIntr | output | 1 | CPU interrupt request |
| cpuNmi | output | 1 | CPU non-maskable interrupt |
| stopFlag | output | 1 | Routine has stopped |

## Verification
Completing a WAITLOCK match lowers the NMI line in the same edge that raises readyN and takes the bus. The bench starts driving the lock and address strobe as soon as it sees cpuNmi rise, so both are already asserted when the wait first enters EXEC. It then checks that cpuNmi falls together with readyN high and busEn high, and that the routine goes on. A second overlap is an address strobe from a memory cycle that arrives during a WAITIO. The bench holds such a strobe across the whole wait and checks that readyN stays low and no register is written. Only then does it turn the cycle into an IO access.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int DATA_W = 16;
  localparam int PC_W   = 8;
  localparam int RIDX_W = 4;
  localparam int MEM_AW = PC_W + 1;
  localparam int BUS_AW = 24;
  localparam int OPC_W  = 8;

  typedef enum logic [2:0] {
    ST_LATCH, ST_FETCH, ST_LOAD, ST_EXEC, ST_STORE
  } seqState_t;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP      = 8'h00, OP_ATTACH = 8'h01, OP_DETACH = 8'h02, OP_LDD   = 8'h03,
    OP_LDAL     = 8'h04, OP_LDAH   = 8'h05, OP_LDWR   = 8'h06, OP_LDDC  = 8'h07,
    OP_LDMIO    = 8'h08, OP_STD    = 8'h09, OP_START  = 8'h0A, OP_RESET = 8'h0B,
    OP_READY    = 8'h0C, OP_LDI    = 8'h0D, OP_MOV    = 8'h0E, OP_CLR   = 8'h0F,
    OP_LDCMP    = 8'h10, OP_CMP    = 8'h11, OP_BA     = 8'h12, OP_BEQ   = 8'h13,
    OP_BNE      = 8'h14, OP_HOLD   = 8'h15, OP_INT    = 8'h16, OP_WAITADS = 8'h17,
    OP_WAITIO   = 8'h18, OP_WAITLOCK = 8'h19, OP_EXIT = 8'h1A, OP_NMI   = 8'h1B
  } seqOp_t;

  typedef struct packed {
    logic latch;
    logic fetch;
    logic load;
    logic exec;
    logic execDone;
    logic store;
    logic waitMatch;
  } seqStrobe_t;
endpackage

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              busAdsN,
  input  logic              busMio,
  input  logic              busLockN,
  input  logic              holdAck,
  input  logic              intAck,
  output logic [DATA_W-1:0] instr,
  output seqStrobe_t        strobe
);
  seqState_t state;
  seqOp_t    opc;
  logic      condMet;
  logic      isWait;

  assign opc = seqOp_t'(instr[DATA_W-1:DATA_W-OPC_W]);

  always_comb begin
    condMet = 1'b1;
    isWait  = 1'b0;
    case (opc)
      OP_HOLD:     condMet = holdAck;
      OP_INT:      condMet = intAck;
      OP_WAITADS:  begin condMet = !busAdsN;               isWait = 1'b1; end
      OP_WAITIO:   begin condMet = !busAdsN && !busMio;    isWait = 1'b1; end
      OP_WAITLOCK: begin condMet = !busAdsN && !busLockN;  isWait = 1'b1; end
      OP_EXIT:     condMet = 1'b0;
      default:     condMet = 1'b1;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.latch     = (state == ST_LATCH);
    strobe.fetch     = (state == ST_FETCH);
    strobe.load      = (state == ST_LOAD);
    strobe.exec      = (state == ST_EXEC);
    strobe.execDone  = (state == ST_EXEC) && condMet;
    strobe.store     = (state == ST_STORE);
    strobe.waitMatch = (state == ST_EXEC) && condMet && isWait;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LATCH;
      instr <= '0;
    end else begin
      case (state)
        ST_LATCH: state <= ST_FETCH;
        ST_FETCH: begin
          instr <= memRdData;
          state <= ST_LOAD;
        end
        ST_LOAD:  state <= ST_EXEC;
        ST_EXEC:  if (condMet) state <= ST_STORE;
        ST_STORE: state <= ST_LATCH;
        default:  state <= ST_LATCH;
      endcase
    end
  end

  p_latch_to_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_LATCH |=> state == ST_FETCH);
  p_fetch_to_load_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |=> state == ST_LOAD);
  p_load_to_exec_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOAD |=> state == ST_EXEC);
  p_store_to_latch_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_STORE |=> state == ST_LATCH);
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && opc == OP_HOLD && !holdAck) |=> state == ST_EXEC);
  p_exit_stall_r13: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && opc == OP_EXIT) |=> state == ST_EXEC);
endmodule

// File: rtl/dbg_seq_dpath.sv
module dbg_seq_dpath
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWr,
  input  logic              busDc,
  input  logic              busMio,
  output logic              busEn,
  output logic              readyN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              cpuReset,
  output logic              cpuHold,
  output logic              cpuIntr,
  output logic              cpuNmi,
  output logic              stopFlag
);
  localparam int HI_W  = BUS_AW - DATA_W;
  localparam int PAD_W = MEM_AW - 1 - RIDX_W;

  seqOp_t            opc;
  logic [PC_W-1:0]   pc;
  logic [DATA_W-1:0] immReg;
  logic [DATA_W-1:0] cmpReg;
  logic [DATA_W-1:0] resReg;
  logic              wrPend;
  logic [RIDX_W-1:0] srcIdx;
  logic [RIDX_W-1:0] dstIdx;
  logic              takeBranch;

  assign opc    = seqOp_t'(instr[DATA_W-1:DATA_W-OPC_W]);
  assign dstIdx = instr[RIDX_W-1:0];
  assign srcIdx = (opc == OP_MOV) ? instr[2*RIDX_W-1:RIDX_W] : instr[RIDX_W-1:0];

  always_comb begin
    if (strobe.fetch)
      memAddr = {1'b0, pc + PC_W'(1)};
    else if (strobe.load || strobe.exec)
      memAddr = {1'b1, {PAD_W{1'b0}}, srcIdx};
    else if (strobe.store)
      memAddr = {1'b1, {PAD_W{1'b0}}, dstIdx};
    else
      memAddr = {1'b0, pc};
  end

  assign memWrEn   = strobe.store && wrPend;
  assign memWrData = resReg;

  always_comb begin
    case (opc)
      OP_BA:   takeBranch = 1'b1;
      OP_BEQ:  takeBranch = (cmpReg != '0);
      OP_BNE:  takeBranch = (cmpReg == '0);
      default: takeBranch = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      immReg   <= '0;
      cmpReg   <= '0;
      resReg   <= '0;
      wrPend   <= 1'b0;
      busEn    <= 1'b0;
      readyN   <= 1'b1;
      dataOut  <= '0;
      dataOe   <= 1'b0;
      cpuReset <= 1'b0;
      cpuHold  <= 1'b0;
      cpuIntr  <= 1'b0;
      cpuNmi   <= 1'b0;
      stopFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        immReg <= memRdData;
        if (opc == OP_HOLD) cpuHold <= 1'b1;
        if (opc == OP_INT)  cpuIntr <= 1'b1;
      end
      if (strobe.exec && opc == OP_EXIT) stopFlag <= 1'b1;
      if (strobe.execDone) begin
        wrPend <= 1'b1;
        case (opc)
          OP_LDD:   resReg <= busData;
          OP_LDAL:  resReg <= busAddr[DATA_W-1:0];
          OP_LDAH:  resReg <= {{(DATA_W-HI_W){1'b0}}, busAddr[BUS_AW-1:DATA_W]};
          OP_LDWR:  resReg <= {{(DATA_W-1){1'b0}}, busWr};
          OP_LDDC:  resReg <= {{(DATA_W-1){1'b0}}, busDc};
          OP_LDMIO: resReg <= {{(DATA_W-1){1'b0}}, busMio};
          OP_LDI:   resReg <= immReg;
          OP_MOV:   resReg <= memRdData;
          OP_CLR:   resReg <= '0;
          default:  wrPend <= 1'b0;
        endcase
        case (opc)
          OP_LDCMP:  cmpReg <= memRdData;
          OP_CMP:    cmpReg <= {{(DATA_W-1){1'b0}}, (cmpReg == memRdData)};
          OP_STD:    begin dataOut <= memRdData; dataOe <= 1'b1; end
          OP_READY:  readyN <= 1'b0;
          OP_ATTACH: busEn <= 1'b1;
          OP_DETACH: begin busEn <= 1'b0; dataOe <= 1'b0; cpuHold <= 1'b0; end
          OP_START:  cpuReset <= 1'b0;
          OP_RESET:  cpuReset <= 1'b1;
          OP_NMI:    cpuNmi <= 1'b1;
          OP_INT:    cpuIntr <= 1'b0;
          OP_WAITADS, OP_WAITIO: begin readyN <= 1'b1; busEn <= 1'b1; end
          OP_WAITLOCK: begin readyN <= 1'b1; busEn <= 1'b1; cpuNmi <= 1'b0; end
          default: ;
        endcase
      end
      if (strobe.store)
        pc <= takeBranch ? instr[PC_W-1:0]
                         : pc + ((opc == OP_LDI) ? PC_W'(2) : PC_W'(1));
    end
  end

  p_write_region_r1: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> memAddr[MEM_AW-1]);
  p_match_attach_r11: assert property (@(posedge clk) disable iff (rst)
    strobe.waitMatch |=> (busEn && readyN));
  p_nmi_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(cpuNmi) |-> $past(strobe.waitMatch));
  p_intr_drop_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cpuIntr) |-> $past(strobe.execDone));
  p_stop_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    stopFlag |=> stopFlag);
  p_no_write_stopped_r13: assert property (@(posedge clk) disable iff (rst)
    stopFlag |-> !memWrEn);
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic              busAdsN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWr,
  input  logic              busDc,
  input  logic              busMio,
  input  logic              busLockN,
  input  logic              holdAck,
  input  logic              intAck,
  output logic              busEn,
  output logic              readyN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              cpuReset,
  output logic              cpuHold,
  output logic              cpuIntr,
  output logic              cpuNmi,
  output logic              stopFlag
);
  seqStrobe_t        strobe;
  logic [DATA_W-1:0] instr;

  dbg_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .memRdData(memRdData),
    .busAdsN(busAdsN), .busMio(busMio), .busLockN(busLockN),
    .holdAck(holdAck), .intAck(intAck),
    .instr(instr), .strobe(strobe)
  );

  dbg_seq_dpath u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .instr(instr),
    .memRdData(memRdData), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .busAddr(busAddr), .busData(busData),
    .busWr(busWr), .busDc(busDc), .busMio(busMio),
    .busEn(busEn), .readyN(readyN), .dataOut(dataOut), .dataOe(dataOe),
    .cpuReset(cpuReset), .cpuHold(cpuHold), .cpuIntr(cpuIntr),
    .cpuNmi(cpuNmi), .stopFlag(stopFlag)
  );
endmodule

// File: tb/dbg_seq_bench.sv
`timescale 1ns/1ps
module dbg_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  memAddr;
  logic [15:0] memRdData;
  logic        memWrEn;
  logic [15:0] memWrData;
  logic        busAdsN = 1'b1;
  logic [23:0] busAddr = '0;
  logic [15:0] busData = '0;
  logic        busWr = 1'b0;
  logic        busDc = 1'b1;
  logic        busMio = 1'b1;
  logic        busLockN = 1'b1;
  logic        holdAck = 1'b0;
  logic        intAck = 1'b0;
  logic        busEn, readyN, dataOe, cpuReset, cpuHold, cpuIntr, cpuNmi, stopFlag;
  logic [15:0] dataOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] mem [0:511];
  logic [24:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  dbg_seq u_dbg_seq (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .busAdsN(busAdsN),
    .busAddr(busAddr), .busData(busData), .busWr(busWr), .busDc(busDc),
    .busMio(busMio), .busLockN(busLockN), .holdAck(holdAck), .intAck(intAck),
    .busEn(busEn), .readyN(readyN), .dataOut(dataOut), .dataOe(dataOe),
    .cpuReset(cpuReset), .cpuHold(cpuHold), .cpuIntr(cpuIntr),
    .cpuNmi(cpuNmi), .stopFlag(stopFlag)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    memRdData <= mem[memAddr];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expectWrite(input string req, input logic [8:0] a, input logic [15:0] d);
    expQ.push_back({a, d});
    tagQ.push_back(req);
  endtask

  // scoreboard monitor: every register write must match the next expected item
  always @(negedge clk) begin
    if (!rst && memWrEn) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R13 unexpected write actual=%h:%h expected=none", memAddr, memWrData);
      end else begin
        logic [24:0] item;
        string tag;
        item = expQ.pop_front();
        tag  = tagQ.pop_front();
        if ({memAddr, memWrData} !== item) begin
          failures++;
          $display("FAIL %s write actual=%h:%h expected=%h:%h",
                   tag, memAddr, memWrData, item[24:16], item[15:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    mem[0]  = 16'h0D0D; mem[1] = 16'h1234;  // LDI R13
    mem[2]  = 16'h0ED2;                     // MOV R2,R13
    mem[3]  = 16'h0100;                     // ATTACH
    mem[4]  = 16'h0902;                     // STD R2
    mem[5]  = 16'h0C00;                     // READY
    mem[6]  = 16'h100D;                     // LDCMP R13
    mem[7]  = 16'h1102;                     // CMP R2
    mem[8]  = 16'h130A;                     // BEQ 10
    mem[9]  = 16'h0F01;                     // CLR R1 (skipped)
    mem[10] = 16'h1800;                     // WAITIO
    mem[11] = 16'h0403;                     // LDAL R3
    mem[12] = 16'h0506;                     // LDAH R6
    mem[13] = 16'h0604;                     // LDWR R4
    mem[14] = 16'h0807;                     // LDMIO R7
    mem[15] = 16'h0308;                     // LDD R8
    mem[16] = 16'h0709;                     // LDDC R9
    mem[17] = 16'h0F02;                     // CLR R2
    mem[18] = 16'h1002;                     // LDCMP R2
    mem[19] = 16'h1415;                     // BNE 21
    mem[20] = 16'h0F01;                     // skipped
    mem[21] = 16'h1217;                     // BA 23
    mem[22] = 16'h0F01;                     // skipped
    mem[23] = 16'h110D;                     // CMP R13 -> 0
    mem[24] = 16'h131A;                     // BEQ 26 (not taken)
    mem[25] = 16'h0D0A; mem[26] = 16'hBEEF; // LDI R10
    mem[27] = 16'h1500;                     // HOLD
    mem[28] = 16'h1600;                     // INT
    mem[29] = 16'h1B00;                     // NMI
    mem[30] = 16'h1900;                     // WAITLOCK
    mem[31] = 16'h0200;                     // DETACH
    mem[32] = 16'h0B00;                     // RESET
    mem[33] = 16'h0A00;                     // START
    mem[34] = 16'h1A00;                     // EXIT

    expectWrite("R4 LDI",  9'h10D, 16'h1234);
    expectWrite("R4 MOV",  9'h102, 16'h1234);
    expectWrite("R5 LDAL", 9'h103, 16'h3C7E);
    expectWrite("R5 LDAH", 9'h106, 16'h005A);
    expectWrite("R5 LDWR", 9'h104, 16'h0001);
    expectWrite("R5 LDMIO",9'h107, 16'h0000);
    expectWrite("R5 LDD",  9'h108, 16'hC0DE);
    expectWrite("R5 LDDC", 9'h109, 16'h0000);
    expectWrite("R4 CLR",  9'h102, 16'h0000);
    expectWrite("R3 branch/R2 LDI", 9'h10A, 16'hBEEF);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", "stop at reset", stopFlag, 0);
    chk("R13", "busEn at reset", busEn, 0);
    chk("R13", "readyN at reset", readyN, 1);
    chk("R13", "drive lines at reset", {dataOe, cpuReset, cpuHold, cpuIntr, cpuNmi}, 0);
    rst = 1'b0;
    chk("R1", "addr LATCH", memAddr, 9'h000);
    @(negedge clk); chk("R1", "addr FETCH", memAddr, 9'h001);
    @(negedge clk); chk("R1", "addr LOAD", memAddr, 9'h10D);
    @(negedge clk); chk("R1", "addr EXEC", memAddr, 9'h10D);
    @(negedge clk); chk("R1", "store write", {memWrEn, memAddr}, {1'b1, 9'h10D});
    @(negedge clk); chk("R2", "pc after LDI", memAddr, 9'h002);

    for (int i = 0; i < 200 && readyN !== 1'b0; i++) @(negedge clk);
    chk("R7", "readyN after READY", readyN, 0);
    chk("R6", "busEn after ATTACH", busEn, 1);
    chk("R7", "data drive", {dataOe, dataOut}, {1'b1, 16'h1234});

    // memory cycle strobe must not satisfy the IO wait
    busAdsN = 1'b0; busMio = 1'b1;
    repeat (60) @(negedge clk);
    chk("R11", "WAITIO ignores memory cycle", readyN, 0);
    busAddr = 24'h5A3C7E; busData = 16'hC0DE; busWr = 1'b1; busDc = 1'b0; busMio = 1'b0;
    for (int i = 0; i < 50 && readyN !== 1'b1; i++) @(negedge clk);
    chk("R11", "WAITIO match readyN", readyN, 1);
    chk("R11", "WAITIO match busEn", busEn, 1);
    busAdsN = 1'b1;

    for (int i = 0; i < 300 && cpuHold !== 1'b1; i++) @(negedge clk);
    chk("R9", "hold raised", cpuHold, 1);
    repeat (10) @(negedge clk);
    chk("R9", "stalled without ack", {cpuHold, cpuIntr}, 2'b10);
    holdAck = 1'b1;
    for (int i = 0; i < 50 && cpuIntr !== 1'b1; i++) @(negedge clk);
    chk("R10", "intr raised", cpuIntr, 1);
    holdAck = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10", "intr held waiting", {cpuIntr, cpuNmi}, 2'b10);
    intAck = 1'b1;
    for (int i = 0; i < 50 && cpuIntr !== 1'b0; i++) @(negedge clk);
    chk("R10", "intr dropped after ack", cpuIntr, 0);
    intAck = 1'b0;

    for (int i = 0; i < 50 && cpuNmi !== 1'b1; i++) @(negedge clk);
    chk("R12", "nmi raised", cpuNmi, 1);
    busAdsN = 1'b0; busLockN = 1'b0;
    for (int i = 0; i < 50 && cpuNmi !== 1'b0; i++) @(negedge clk);
    chk("R12", "nmi cleared by lock match", cpuNmi, 0);
    chk("R11", "lock match ready/attach", {readyN, busEn}, 2'b11);
    busAdsN = 1'b1; busLockN = 1'b1;

    for (int i = 0; i < 50 && busEn !== 1'b0; i++) @(negedge clk);
    chk("R6", "DETACH releases", {busEn, dataOe, cpuHold}, 3'b000);
    for (int i = 0; i < 50 && cpuReset !== 1'b1; i++) @(negedge clk);
    chk("R8", "RESET raises", cpuReset, 1);
    for (int i = 0; i < 50 && cpuReset !== 1'b0; i++) @(negedge clk);
    chk("R8", "START lowers", cpuReset, 0);
    for (int i = 0; i < 50 && stopFlag !== 1'b1; i++) @(negedge clk);
    chk("R13", "stop on EXIT", stopFlag, 1);
    chk("R3", "pending writes", expQ.size(), 0);
    repeat (30) @(negedge clk);
    chk("R13", "stop sticky", stopFlag, 1);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13", "stop cleared by reset", stopFlag, 0);
    expectWrite("R13 restart", 9'h10D, 16'h1234);
    expectWrite("R13 restart", 9'h102, 16'h1234);
    rst = 1'b0;
    for (int i = 0; i < 100 && expQ.size() != 0; i++) @(negedge clk);
    chk("R13", "restart from word 0", expQ.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule